// File: doc/BRIEF.md
# Toggle-Based Pulse Clock-Domain Synchronizer

This block moves single-cycle event pulses from a fast source clock into an unrelated, slower destination clock. The two clocks have no fixed phase, and the phase may drift. Each accepted event inverts a toggle flop in the source domain. Only the level of that flop crosses the boundary. In the destination domain the level passes down a chain of flops, and the XOR of the last two stages rebuilds the event as a pulse exactly one destination cycle wide. The direction of the toggle has no meaning.

There are two build-time modes. In open mode the source flips its flop on every event, so the sender must space events far enough apart. In feedback mode the first destination stage is synchronized back into the source domain. The toggle flop then loads the inverse of that returned level, so only one transition can be in flight at a time. An event that arrives while a transition is still outstanding is rejected and flagged for one source cycle.

A delay tap is a shift register in the destination domain. It repeats every recovered pulse as a strobe a fixed number of destination cycles later, for pipeline alignment.

Top module: `pulse_cdc_sync`

## Requirements
- R1: While either reset is low, and after both are released with no event, `dst_pulse_o`, `dst_strobe_o` and `src_drop_o` are 0.
- R2: Each accepted source event produces exactly one `dst_pulse_o` assertion, and that assertion is exactly one destination cycle wide.
- R3: After the source edge that captures the event, `dst_pulse_o` is first high in the destination cycle that follows the 2nd, 3rd or 4th destination rising edge. With the default three-stage chain the nominal case is the 2nd edge.
- R4: In open mode, a burst of events with consecutive events at least three destination periods apart delivers exactly as many pulses as there were events.
- R5: Events that drive the toggle from 0 to 1 and from 1 to 0 each produce a pulse; only the change of level matters.
- R6: In feedback mode, an event captured while a transition is still unacknowledged raises `src_drop_o` for exactly the one source cycle after the capturing edge, and produces no destination pulse.
- R7: In feedback mode, an event captured after the previous transition has been acknowledged is accepted: `src_drop_o` stays 0 and one pulse is delivered.
- R8: `dst_strobe_o` is high in the destination cycle exactly DELAY cycles (default 14) after a cycle in which `dst_pulse_o` was high, and at no other time.
- R9: Several pulses that fall within one delay window each produce their own strobe.
- R10: In open mode, `src_drop_o` is never asserted.
- R11: Delivery, pulse width and latency hold with a non-integer clock ratio and a destination clock whose phase drifts randomly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Source-domain clock |
| src_rst_ni | input | 1 | Source-domain asynchronous reset, active low |
| src_event_i | input | 1 | Single-cycle event in the source domain |
| src_drop_o | output | 1 | Feedback mode only: the event was rejected because a transition is still outstanding |
| dst_clk_i | input | 1 | Destination-domain clock |
| dst_rst_ni | input | 1 | Destination-domain asynchronous reset, active low |
| dst_pulse_o | output | 1 | Recovered one-cycle pulse in the destination domain |
| dst_strobe_o | output | 1 | Recovered pulse delayed by DELAY destination cycles |

## Verification
The embedded assertions check four things on every cycle:
- a recovered pulse never lasts longer than one destination cycle;
- in open mode, the source toggle changes only on an event;
- in feedback mode, the toggle never changes while a transition is outstanding, and the drop flag rises only for an event that arrived during that busy time;
- no strobe appears without a pending pulse in the delay window.

Only the bench scenarios can show the rest. These are end-to-end delivery counts, the latency window measured from the capturing source edge, the exact strobe offset, and that a rejected event yields no pulse while a later one is accepted. All of these run under a drifting destination clock.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic {
    PCS_OPEN     = 1'b0,
    PCS_FEEDBACK = 1'b1
  } pcs_mode_e;

  localparam int PCS_MIN_SYNC = 3;
  localparam int PCS_MIN_ACK  = 2;
endpackage

// File: rtl/pcs_src_toggle.sv
module pcs_src_toggle
  import pcs_pkg::*;
#(
  parameter pcs_mode_e MODE       = PCS_OPEN,
  parameter int        ACK_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic ack_i,
  output logic tog_o,
  output logic drop_o
);
  localparam int AS = (ACK_STAGES < PCS_MIN_ACK) ? PCS_MIN_ACK : ACK_STAGES;

  logic tog_q, tog_d;
  logic drop_q, drop_d;
  logic busy;

  generate
    if (MODE == PCS_FEEDBACK) begin : g_fb
      logic [AS-1:0] ack_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ack_q <= '0;
        else         ack_q <= {ack_q[AS-2:0], ack_i};
      end

      // outstanding while the returned level differs from the launched one
      assign busy   = tog_q ^ ack_q[AS-1];
      assign tog_d  = (event_i && !busy) ? ~ack_q[AS-1] : tog_q;
      assign drop_d = event_i & busy;

      AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(tog_q) |-> (!$past(busy) && $past(event_i))) else $error("toggle while busy"); // R6
      AST_DROP_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drop_q |-> ($past(event_i) && $past(busy))) else $error("spurious drop"); // R6
      AST_DROP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drop_q && !event_i) |=> !drop_q) else $error("drop too long"); // R6
    end else begin : g_open
      logic unused_ack;
      assign unused_ack = ack_i;
      assign busy       = 1'b0;
      assign tog_d      = event_i ? ~tog_q : tog_q;
      assign drop_d     = 1'b0;

      AST_TOGGLE_ON_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(tog_q) |-> $past(event_i)) else $error("toggle without event"); // R2
      AST_NO_DROP_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !drop_q) else $error("drop in open mode"); // R10
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      tog_q  <= tog_d;
      drop_q <= drop_d;
    end
  end

  assign tog_o  = tog_q;
  assign drop_o = drop_q;
endmodule

// File: rtl/pcs_dst_recover.sv
module pcs_dst_recover
  import pcs_pkg::*;
#(
  parameter int SYNC_DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tog_i,
  output logic seen_o,
  output logic pulse_o
);
  localparam int SD = (SYNC_DEPTH < PCS_MIN_SYNC) ? PCS_MIN_SYNC : SYNC_DEPTH;

  logic [SD-1:0] sync_q;

  // only sync_q[0] samples the asynchronous level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SD-2:0], tog_i};
  end

  assign seen_o  = sync_q[0];
  assign pulse_o = sync_q[SD-1] ^ sync_q[SD-2];

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o) else $error("pulse wider than one cycle"); // R2
endmodule

// File: rtl/pcs_delay_tap.sv
module pcs_delay_tap #(
  parameter int DELAY = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic strobe_o
);
  localparam int DL = (DELAY < 1) ? 1 : DELAY;
  localparam int CW = $clog2(DL + 2);

  logic [DL-1:0] line_q;

  generate
    if (DL == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) line_q <= '0;
        else         line_q <= pulse_i;
      end
    end else begin : g_line
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) line_q <= '0;
        else         line_q <= {line_q[DL-2:0], pulse_i};
      end
    end
  endgenerate

  assign strobe_o = line_q[DL-1];

  // pending pulses inside the window, for the check below
  logic [CW-1:0] pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_q + CW'(pulse_i) - CW'(strobe_o);
  end

  AST_STROBE_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> (pend_q != '0)) else $error("strobe without pending pulse"); // R8
endmodule

// File: rtl/pulse_cdc_sync.sv
module pulse_cdc_sync
  import pcs_pkg::*;
#(
  parameter pcs_mode_e MODE       = PCS_OPEN,
  parameter int        SYNC_DEPTH = 3,
  parameter int        ACK_STAGES = 2,
  parameter int        DELAY      = 14
) (
  input  logic src_clk_i,
  input  logic src_rst_ni,
  input  logic src_event_i,
  output logic src_drop_o,
  input  logic dst_clk_i,
  input  logic dst_rst_ni,
  output logic dst_pulse_o,
  output logic dst_strobe_o
);
  logic tog;
  logic seen;
  logic pulse;

  pcs_src_toggle #(
    .MODE      (MODE),
    .ACK_STAGES(ACK_STAGES)
  ) u_src (
    .clk_i  (src_clk_i),
    .rst_ni (src_rst_ni),
    .event_i(src_event_i),
    .ack_i  (seen),
    .tog_o  (tog),
    .drop_o (src_drop_o)
  );

  pcs_dst_recover #(
    .SYNC_DEPTH(SYNC_DEPTH)
  ) u_dst (
    .clk_i  (dst_clk_i),
    .rst_ni (dst_rst_ni),
    .tog_i  (tog),
    .seen_o (seen),
    .pulse_o(pulse)
  );

  pcs_delay_tap #(
    .DELAY(DELAY)
  ) u_tap (
    .clk_i   (dst_clk_i),
    .rst_ni  (dst_rst_ni),
    .pulse_i (pulse),
    .strobe_o(dst_strobe_o)
  );

  assign dst_pulse_o = pulse;

  AST_RESET_QUIET: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    $rose(dst_rst_ni) |-> (!dst_pulse_o && !dst_strobe_o)) else $error("output after reset"); // R1
endmodule

// File: tb/pulse_cdc_sync_bench.sv
`timescale 1ns/1ps
module pulse_cdc_sync_bench;
  import pcs_pkg::*;

  localparam int TAP = 14;

  logic src_clk = 1'b0;
  logic dst_clk = 1'b0;
  logic src_rst_n = 1'b0;
  logic dst_rst_n = 1'b0;
  logic ev_a = 1'b0, ev_b = 1'b0;
  logic drop_a, drop_b, pulse_a, pulse_b, strobe_a, strobe_b;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 src_clk = ~src_clk;  // 125 MHz

  // destination clock: ~66.7 MHz with random phase drift
  initial begin
    #0.37;
    forever begin
      real hp;
      hp = 7.5 + (real'(int'($urandom % 7)) - 3.0) * 0.011;
      #(hp) dst_clk = ~dst_clk;
    end
  end

  pulse_cdc_sync #(.MODE(PCS_OPEN), .DELAY(TAP)) u_pulse_cdc_sync (
    .src_clk_i(src_clk), .src_rst_ni(src_rst_n), .src_event_i(ev_a), .src_drop_o(drop_a),
    .dst_clk_i(dst_clk), .dst_rst_ni(dst_rst_n), .dst_pulse_o(pulse_a), .dst_strobe_o(strobe_a));

  pulse_cdc_sync #(.MODE(PCS_FEEDBACK), .DELAY(TAP)) u_pulse_cdc_sync_fb (
    .src_clk_i(src_clk), .src_rst_ni(src_rst_n), .src_event_i(ev_b), .src_drop_o(drop_b),
    .dst_clk_i(dst_clk), .dst_rst_ni(dst_rst_n), .dst_pulse_o(pulse_b), .dst_strobe_o(strobe_b));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitors
  int  dst_edges = 0;
  real last_dst_t = -1.0;
  always @(posedge dst_clk) begin
    dst_edges++;
    last_dst_t = $realtime;
  end

  int pulses_a = 0, pulses_b = 0, strobes_a = 0;
  int width_err = 0, tap_err = 0, drop_a_seen = 0;
  bit prev_a = 1'b0, prev_b = 1'b0;
  bit hist [TAP];

  initial for (int i = 0; i < TAP; i++) hist[i] = 1'b0;

  always @(negedge dst_clk) begin
    if (dst_rst_n) begin
      if (pulse_a) pulses_a++;
      if (pulse_b) pulses_b++;
      if (strobe_a) strobes_a++;
      if ((pulse_a && prev_a) || (pulse_b && prev_b)) width_err++;
      if (strobe_a != hist[TAP-1]) tap_err++;
      for (int i = TAP-1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = pulse_a;
      prev_a = pulse_a;
      prev_b = pulse_b;
    end
  end

  always @(negedge src_clk) if (src_rst_n && drop_a) drop_a_seen++;

  // drive one event on the chosen instance; returns dst edge count at capture
  task automatic fire(input bit fb, output int e0, output bit drop_seen);
    @(negedge src_clk);
    if (fb) ev_b = 1'b1; else ev_a = 1'b1;
    @(posedge src_clk);
    e0 = (last_dst_t == $realtime) ? dst_edges - 1 : dst_edges;
    @(negedge src_clk);
    ev_a = 1'b0;
    ev_b = 1'b0;
    drop_seen = fb ? drop_b : drop_a;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge src_clk);
    chk(!pulse_a && !strobe_a && !drop_a && !pulse_b && !drop_b, "R1", "outputs in reset", 0, 0);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    repeat (10) @(negedge src_clk);
    chk(!pulse_a && !strobe_a && !drop_a && !pulse_b && !strobe_b && !drop_b, "R1", "outputs idle", 0, 0);
    chk(pulses_a == 0 && pulses_b == 0, "R1", "no pulses after reset", pulses_a + pulses_b, 0);
  endtask

  task automatic t_latency();
    for (int n = 0; n < 6; n++) begin
      int e0, lat, p0;
      bit d;
      p0 = pulses_a;
      fire(1'b0, e0, d);
      lat = -1;
      for (int k = 0; k < 12; k++) begin
        @(negedge dst_clk);
        if (pulse_a) begin
          lat = dst_edges - e0;
          break;
        end
      end
      chk(lat >= 2 && lat <= 4, "R3", "latency in dst edges", lat, 3);
      repeat (4) @(negedge dst_clk);
      chk(pulses_a == p0 + 1, n[0] ? "R5" : "R2", "one pulse per event", pulses_a - p0, 1);
    end
    chk(width_err == 0, "R2", "pulse width errors", width_err, 0);
  endtask

  task automatic t_burst();
    int p0, s0, e0;
    bit d;
    repeat (30) @(negedge dst_clk);
    p0 = pulses_a;
    s0 = strobes_a;
    for (int n = 0; n < 10; n++) begin
      fire(1'b0, e0, d);
      repeat (5) @(negedge src_clk);  // 7 src cycles between events
    end
    repeat (30) @(negedge dst_clk);
    chk(pulses_a - p0 == 10, "R4", "burst delivery", pulses_a - p0, 10);
    chk(strobes_a - s0 == 10, "R9", "strobes for clustered pulses", strobes_a - s0, 10);
    chk(width_err == 0, "R11", "width under drift", width_err, 0);
  endtask

  task automatic t_tap();
    int e0;
    bit d;
    fire(1'b0, e0, d);
    repeat (40) @(negedge dst_clk);
    chk(tap_err == 0, "R8", "strobe offset mismatches", tap_err, 0);
    chk(strobes_a == pulses_a, "R8", "strobe count", strobes_a, pulses_a);
  endtask

  task automatic t_fb_drop();
    int e0, p0;
    bit d1, d2, d3;
    p0 = pulses_b;
    fire(1'b1, e0, d1);
    fire(1'b1, e0, d2);
    @(negedge src_clk);
    d3 = drop_b;
    chk(!d1, "R7", "first event not dropped", d1, 0);
    chk(d2, "R6", "second event dropped", d2, 1);
    chk(!d3, "R6", "drop lasts one cycle", d3, 0);
    repeat (40) @(negedge src_clk);
    chk(pulses_b - p0 == 1, "R6", "dropped event gives no pulse", pulses_b - p0, 1);
  endtask

  task automatic t_fb_accept();
    int e0, p0;
    bit d;
    p0 = pulses_b;
    for (int n = 0; n < 4; n++) begin
      fire(1'b1, e0, d);
      chk(!d, "R7", "acknowledged event accepted", d, 0);
      repeat (20) @(negedge src_clk);
    end
    repeat (20) @(negedge src_clk);
    chk(pulses_b - p0 == 4, "R7", "feedback delivery", pulses_b - p0, 4);
    chk(width_err == 0, "R2", "feedback pulse width", width_err, 0);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_burst();
    t_tap();
    t_fb_drop();
    t_fb_accept();
    chk(drop_a_seen == 0, "R10", "open mode drop count", drop_a_seen, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule